// File: doc/BRIEF.md
# MDIO Management Master

This block lets software reach the management registers of an Ethernet PHY over the two-wire MDIO/MDC bus. Software uses a small word-addressed register file. It loads a target PHY address, a register number and a read/write selector into the command register, and a 16-bit value into the write-data register when the operation is a write. It then sets the go bit in the control register. The block builds a complete Clause 22 management frame and shifts it out on MDIO, timed by an MDC clock derived from the system clock. It clears the go bit when the last MDC period ends.

A single control bit serves two purposes. Writing 1 to it starts a frame, and reading it back shows whether a frame is still in progress. A separate enable bit gates the master, and a request made while that bit is clear is dropped. On a read, the block stops driving MDIO from the turnaround onward and shifts in the PHY's 16 data bits, most significant first. If no PHY answers, the external pull-up keeps the line high and the result is 0xFFFF.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word reads 0, MDC is low and the MDIO output enable is low.
- R2: Register select 0 is the command register. Its bits 4:0 hold the PHY register number, bits 9:5 the PHY address, and bit 10 the operation (1 = read, 0 = write). It reads back as written, and bits above 10 read 0. Select 1 holds the 16-bit write data and reads back in bits 15:0.
- R3: Control (select 3) bit 3 is the master enable and reads back as written. A write that sets bit 0 while the bit 3 value being written is 0 starts nothing, and bit 0 reads 0 afterwards.
- R4: A control write with bits 0 and 3 both set, made while idle, sets bit 0. Bit 0 reads 1 for exactly 128×CLK_DIV system clocks (64 MDC periods) and then reads 0. MDC stays low while idle.
- R5: A write frame, sampled on the MDC rising edges, is in order: 32 ones, 01, 01, the 5-bit PHY address MSB first, the 5-bit register number MSB first, 10, then the 16 write-data bits MSB first. MDIO is driven for all 64 bits.
- R6: A read frame carries the same preamble, start, PHY address and register number, with opcode 10. The output enable is high for the first 46 bits and low for the last 18 (turnaround and data).
- R7: The 16 bits sampled on MDC rising edges during the data phase of a read appear MSB first in bits 15:0 of the read-data register (select 2) once bit 0 has cleared.
- R8: A read to which no PHY responds, with the line pulled high, returns 0xFFFF.
- R9: An MDC period is 2×CLK_DIV system clocks. The MDIO output changes only while MDC is low, never while it is high.
- R10: While a frame runs, a control write with bit 0 clear does not abort it, and a control write with bit 0 set does not restart it. The busy time stays 128×CLK_DIV clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 write data, 2 read data, 3 control |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Value of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO driver enable |
| mdio_i | input | 1 | MDIO line as seen on the pad |

## Verification
The assertions assume that software starts a frame only after bit 0 reads 0. They also assume that mdio_i comes from a PHY that changes the line only after an MDC falling edge. The stimulus polls bit 0 before each new request. Its PHY model updates its drive only on MDC falling edges and otherwise leaves the pull-up in control. The only deliberate mid-frame writes are the control writes used to show that such writes neither abort nor restart a frame.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int DCW      = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int FRAME_W  = 64;
  localparam int TA_BIT   = 46;
  localparam int DATA_BIT = 48;

  logic [4:0]     phy_q, regn_q;
  logic           rd_q, en_q, busy_q, cur_rd;
  logic [15:0]    wdat_q, rdat_q;
  logic [DCW-1:0] dcnt;
  logic [5:0]     bitcnt;
  logic [FRAME_W-1:0] frame;

  wire go     = reg_we && reg_sel == 2'd3 && reg_wdata[0] && reg_wdata[3] && !busy_q;
  wire tick   = dcnt == DCW'(CLK_DIV - 1);
  wire rising = busy_q && tick && !mdc;
  wire fallng = busy_q && tick && mdc;

  assign mdio_o = frame[FRAME_W-1];

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {21'd0, rd_q, phy_q, regn_q};
      2'd1:    reg_rdata = {16'd0, wdat_q};
      2'd2:    reg_rdata = {16'd0, rdat_q};
      default: reg_rdata = {28'd0, en_q, 2'b00, busy_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_q <= '0; regn_q <= '0; rd_q <= 1'b0; wdat_q <= '0; en_q <= 1'b0;
    end else if (reg_we) begin
      case (reg_sel)
        2'd0: begin regn_q <= reg_wdata[4:0]; phy_q <= reg_wdata[9:5]; rd_q <= reg_wdata[10]; end
        2'd1: wdat_q <= reg_wdata[15:0];
        2'd3: en_q <= reg_wdata[3];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; cur_rd <= 1'b0; mdc <= 1'b0; mdio_oe <= 1'b0;
      dcnt <= '0; bitcnt <= '0; frame <= '0; rdat_q <= '0;
    end else if (go) begin
      busy_q  <= 1'b1;
      cur_rd  <= rd_q;
      mdc     <= 1'b0;
      mdio_oe <= 1'b1;
      dcnt    <= '0;
      bitcnt  <= '0;
      frame   <= {32'hFFFF_FFFF, 2'b01, rd_q ? 2'b10 : 2'b01, phy_q, regn_q,
                  rd_q ? 2'b11 : 2'b10, rd_q ? 16'hFFFF : wdat_q};
    end else if (busy_q) begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (rising) begin
        mdc <= 1'b1;
        if (cur_rd && bitcnt >= 6'(DATA_BIT)) rdat_q <= {rdat_q[14:0], mdio_i};
      end
      if (fallng) begin
        mdc <= 1'b0;
        if (bitcnt == 6'(FRAME_W - 1)) begin
          busy_q  <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          bitcnt <= bitcnt + 1'b1;
          frame  <= {frame[FRAME_W-2:0], 1'b1};
          if (cur_rd && bitcnt == 6'(TA_BIT - 1)) mdio_oe <= 1'b0;
        end
      end
    end
  end

  AST_IDLE_MDC_LOW:     assert property (@(posedge clk) disable iff (!rst_n) !busy_q |-> !mdc);                 // R4
  AST_IDLE_RELEASED:    assert property (@(posedge clk) disable iff (!rst_n) !busy_q |-> !mdio_oe);             // R1
  AST_START_NEEDS_EN:   assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_q) |-> en_q);           // R3
  AST_READ_RELEASE:     assert property (@(posedge clk) disable iff (!rst_n)
                          (busy_q && cur_rd && bitcnt >= 6'(TA_BIT)) |-> !mdio_oe);                             // R6
  AST_MDO_HOLD_HIGH:    assert property (@(posedge clk) disable iff (!rst_n) mdc |-> $stable(mdio_o));          // R9
  AST_END_ON_LOW:       assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_q) |-> !mdc);           // R4

endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_line;
  logic drv_en = 1'b0, drv_val = 1'b1;
  logic phy_present = 1'b0, phy_rd = 1'b0;
  logic [15:0] phy_data = '0;
  logic cap_clr = 1'b0;
  logic [63:0] cap, oecap;
  int pcnt, cyc = 0, last_rise = 0, per = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mdio_line = mdio_oe ? mdio_o : (drv_en ? drv_val : 1'b1);

  mdio_master #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line));

  always @(posedge mdc or posedge cap_clr) begin
    if (cap_clr) begin
      pcnt <= 0; cap <= '0; oecap <= '0;
    end else begin
      cap <= {cap[62:0], mdio_line};
      oecap <= {oecap[62:0], mdio_oe};
      pcnt <= pcnt + 1;
      per <= cyc - last_rise;
      last_rise <= cyc;
    end
  end

  always @(negedge mdc) begin
    if (phy_present && phy_rd && pcnt >= 47 && pcnt <= 63) begin
      drv_en <= 1'b1;
      drv_val <= (pcnt == 47) ? 1'b0 : phy_data[63 - pcnt];
    end else drv_en <= 1'b0;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    reg_sel = 2'd3; #1;
    while (reg_rdata[0] && n < 50000) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic xfer(input bit isrd, input logic [4:0] phy, input logic [4:0] rg,
                      input logic [15:0] d, output int n);
    @(negedge clk); cap_clr = 1'b1; #1 cap_clr = 1'b0;
    phy_rd = isrd;
    wr(2'd0, {21'd0, isrd, phy, rg});
    if (!isrd) wr(2'd1, {16'd0, d});
    wr(2'd3, 32'h9);
    wait_idle(n);
  endtask

  function automatic logic [63:0] exp_frame(bit isrd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, isrd ? 2'b10 : 2'b01, phy, rg, 2'b10, d};
  endfunction

  initial begin
    #900000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd3, v); chk("R1 ctrl", v, 0);
    #1 chk("R1 mdc/oe", {mdc, mdio_oe}, 0);

    wr(2'd0, 32'hFFFF_F5A7); rd(2'd0, v); chk("R2 cmd", v, 32'h5A7);
    wr(2'd1, 32'hDEAD_BEEF); rd(2'd1, v); chk("R2 wdata", v, 32'hBEEF);

    wr(2'd3, 32'h1); rd(2'd3, v); chk("R3 start ignored", v, 0);
    repeat (10) @(negedge clk); #1 chk("R3 no mdc", {mdc, mdio_oe}, 0);
    wr(2'd3, 32'h8); rd(2'd3, v); chk("R3 enable", v, 8);

    for (int p = 0; p < 32; p++) begin
      logic [15:0] d = 16'(p * 16'h0813) ^ 16'hA5C3;
      xfer(0, 5'(p), 5'(p ^ 31), d, n);
      chk("R4 busy len", 64'(n), 64'(128 * DIV));
      chk("R5 write frame", cap, exp_frame(0, 5'(p), 5'(p ^ 31), d));
      chk("R5 write oe", oecap, 64'hFFFF_FFFF_FFFF_FFFF);
      #1 chk("R4 mdc idle", {63'd0, mdc}, 0);
    end
    chk("R9 period", 64'(per), 64'(2 * DIV));

    phy_present = 1'b1;
    for (int p = 0; p < 32; p++) begin
      logic [15:0] d = 16'(p * 16'h1357) ^ 16'h3C0F;
      phy_data = d;
      xfer(1, 5'(p), 5'(p * 3), 16'h0, n);
      chk("R6 read header", {18'd0, cap[63:18]}, {18'd0, exp_frame(1, 5'(p), 5'(p * 3), 16'h0) >> 18});
      chk("R6 read oe", oecap, 64'hFFFF_FFFF_FFFC_0000);
      rd(2'd2, v); chk("R7 read data", v, {16'd0, d});
    end

    phy_present = 1'b0;
    xfer(1, 5'd9, 5'd1, 16'h0, n);
    rd(2'd2, v); chk("R8 absent phy", v, 32'hFFFF);

    @(negedge clk); cap_clr = 1'b1; #1 cap_clr = 1'b0;
    phy_rd = 1'b0;
    wr(2'd0, {21'd0, 1'b0, 5'd3, 5'd4});
    wr(2'd1, 32'h1234);
    wr(2'd3, 32'h9);
    repeat (40) @(negedge clk);
    wr(2'd3, 32'h8);
    repeat (40) @(negedge clk);
    wr(2'd3, 32'h9);
    wait_idle(n);
    chk("R10 total busy", 64'(n + 84), 64'(128 * DIV));
    chk("R10 frame intact", cap, exp_frame(0, 5'd3, 5'd4, 16'h1234));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule